// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit converts a logical address, made of a 16-bit segment value or selector together with an offset, into a flat address. It works in one of two modes. In real mode it shifts the segment value left by four bits and adds a 16-bit offset, producing a 20-bit physical address that wraps within 20 bits. In protected mode it decodes the selector, picks a descriptor from a global or a local descriptor table, checks the offset against the descriptor's limit, and adds the 32-bit descriptor base.

Both descriptor tables are small register arrays, loaded through a single-cycle write port that names the table, the entry index and the descriptor fields (base, 20-bit limit, granularity, present). A request strobe launches one translation. The address, a valid flag and a fault flag appear registered one clock later. Privilege comparison, paging and memory access belong to other blocks.

Top module: `segxlat_unit`

## Requirements
- R1: In real mode the result is `((selector << 4) + offset[15:0]) mod 2^20`, placed in `addr_out[19:0]` with `addr_out[31:20]` zero and `addr_valid` high (for example 1100h:0450h gives 11450h).
- R2: A real-mode sum that carries out of bit 19 wraps within 20 bits (FFFFh:0010h gives 00000h, FFFFh:FFFFh gives 0FFEFh).
- R3: Real mode never raises `addr_fault`, and ignores `off_wide` and `offset[31:16]`.
- R4: In protected mode `selector[15:3]` is the descriptor index, `selector[2]` picks the table (0 global, 1 local), and `selector[1:0]` has no effect on the result.
- R5: A protected-mode hit gives `addr_out = (base + offset_eff) mod 2^32` with `addr_valid` high. A flat descriptor (base 0, limit FFFFFh, granularity 1) passes every 32-bit offset unchanged.
- R6: `off_wide = 0` zero-extends `offset[15:0]` to form `offset_eff`, and `off_wide = 1` uses all 32 bits, for both the limit check and the sum.
- R7: With granularity 0 the limit counts bytes. `offset_eff <= limit` passes and `offset_eff > limit` faults.
- R8: With granularity 1 the byte limit is `(limit << 12) | FFFh`.
- R9: Selecting an entry whose present bit is 0 faults.
- R10: An index at or above the implemented table depth (`TBL_DEPTH`, default 16) faults.
- R11: Outputs follow a strobe by exactly one clock. A cycle without a strobe gives `addr_valid = addr_fault = 0`. `addr_valid` and `addr_fault` are never both high, and a fault drives `addr_out` to zero.
- R12: Synchronous reset (`rst` high) clears every entry of both tables to not-present and clears the outputs.
- R13: A request in the same cycle as a descriptor write sees the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request strobe |
| mode_prot | input | 1 | 1 = protected mode, 0 = real mode |
| selector | input | 16 | Segment value or selector |
| offset | input | 32 | Offset |
| off_wide | input | 1 | 1 = 32-bit offset, 0 = 16-bit offset |
| wr_en | input | 1 | Descriptor write enable |
| wr_local | input | 1 | Write target table, 0 global, 1 local |
| wr_index | input | TBL_IW | Entry written |
| wr_base | input | 32 | Descriptor base |
| wr_limit | input | 20 | Descriptor limit |
| wr_gran | input | 1 | Granularity, 1 = 4 KB units |
| wr_present | input | 1 | Present bit |
| addr_out | output | 32 | Translated address |
| addr_valid | output | 1 | Translation succeeded |
| addr_fault | output | 1 | Translation faulted |

## Verification
The assertions check on every cycle that valid and fault are exclusive, that an idle cycle yields neither, that real-mode requests never fault and stay within 20 bits, that a faulting result carries a zero address, and that an over-limit offset from the protected path turns into a fault. Only the bench scenarios can show the arithmetic values themselves: the 20-bit wrap, the granularity scaling at the exact limit boundary, global versus local selection, the zero-extension of narrow offsets, the depth bound, and the read-before-write order when a load and a request share a cycle.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;
   localparam int LIN_W      = 32;
   localparam int LIM_W      = 20;
   localparam int SEL_W      = 16;
   localparam int SEL_IDX_W  = 13;
   localparam int GRAN_SHIFT = 12;
   localparam int REAL_SHIFT = 4;
   localparam int REAL_W     = 20;

   typedef struct packed {
      logic [LIN_W-1:0] base;
      logic [LIM_W-1:0] limit;
      logic             gran;
      logic             present;
   } seg_desc_t;
endpackage

// File: rtl/segxlat_desc_table.sv
module segxlat_desc_table
   import segxlat_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [IW-1:0]        wr_idx,
   input  seg_desc_t            wr_desc,
   input  logic [SEL_IDX_W-1:0] rd_idx,
   output seg_desc_t            rd_desc,
   output logic                 rd_in_range
);
   generate
      if (DEPTH < 2 || DEPTH > (1 << SEL_IDX_W)) begin : g_bad_depth
         $error("segxlat_desc_table: DEPTH out of range");
      end
   endgenerate

   seg_desc_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
         mem[wr_idx] <= wr_desc;
      end
   end

   always_comb begin
      rd_in_range = (int'(rd_idx) < DEPTH);
      rd_desc     = rd_in_range ? mem[rd_idx[IW-1:0]] : '0;
   end
endmodule

// File: rtl/segxlat_real_path.sv
module segxlat_real_path
   import segxlat_pkg::*;
(
   input  logic [SEL_W-1:0]  seg,
   input  logic [15:0]       off16,
   output logic [REAL_W-1:0] phys
);
   localparam int SEG_EXT = REAL_W - SEL_W;

   generate
      if (SEG_EXT != REAL_SHIFT) begin : g_bad_shift
         $error("segxlat_real_path: shift does not match width");
      end
   endgenerate

   always_comb begin
      phys = {seg, {REAL_SHIFT{1'b0}}} + {{SEG_EXT{1'b0}}, off16};
   end
endmodule

// File: rtl/segxlat_prot_path.sv
module segxlat_prot_path
   import segxlat_pkg::*;
(
   input  seg_desc_t        desc,
   input  logic             in_range,
   input  logic [LIN_W-1:0] off,
   input  logic             off_wide,
   output logic [LIN_W-1:0] lin,
   output logic             over_limit,
   output logic             fault
);
   localparam int LIM_PAD = LIN_W - LIM_W - GRAN_SHIFT;

   generate
      if (LIM_PAD < 0) begin : g_bad_lim
         $error("segxlat_prot_path: limit does not fit the address");
      end
   endgenerate

   logic [LIN_W-1:0] off_eff;
   logic [LIN_W-1:0] lim_eff;

   always_comb begin
      off_eff = off_wide ? off : {{(LIN_W-16){1'b0}}, off[15:0]};
      if (desc.gran)
         lim_eff = {{LIM_PAD{1'b0}}, desc.limit, {GRAN_SHIFT{1'b1}}};
      else
         lim_eff = {{(LIN_W-LIM_W){1'b0}}, desc.limit};
      over_limit = off_eff > lim_eff;
      fault      = !in_range || !desc.present || over_limit;
      lin        = desc.base + off_eff;
   end
endmodule

// File: rtl/segxlat_unit.sv
module segxlat_unit
   import segxlat_pkg::*;
#(
   parameter int TBL_DEPTH = 16,
   localparam int TBL_IW   = $clog2(TBL_DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              mode_prot,
   input  logic [15:0]       selector,
   input  logic [31:0]       offset,
   input  logic              off_wide,
   input  logic              wr_en,
   input  logic              wr_local,
   input  logic [TBL_IW-1:0] wr_index,
   input  logic [31:0]       wr_base,
   input  logic [19:0]       wr_limit,
   input  logic              wr_gran,
   input  logic              wr_present,
   output logic [31:0]       addr_out,
   output logic              addr_valid,
   output logic              addr_fault
);
   localparam int NUM_TBL = 2;

   generate
      if (TBL_DEPTH < 2 || TBL_DEPTH > 8192) begin : g_bad_depth
         $error("segxlat_unit: TBL_DEPTH out of range");
      end
   endgenerate

   seg_desc_t            wdesc;
   seg_desc_t            tbl_desc  [NUM_TBL];
   logic [NUM_TBL-1:0]   tbl_inrng;
   logic [SEL_IDX_W-1:0] sel_idx;
   logic                 sel_local;

   assign wdesc     = '{base: wr_base, limit: wr_limit, gran: wr_gran, present: wr_present};
   assign sel_idx   = selector[15:3];
   assign sel_local = selector[2];

   for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
      segxlat_desc_table #(.DEPTH(TBL_DEPTH)) u_tbl (
         .clk        (clk),
         .rst        (rst),
         .wr_en      (wr_en && (wr_local == (t == 1))),
         .wr_idx     (wr_index),
         .wr_desc    (wdesc),
         .rd_idx     (sel_idx),
         .rd_desc    (tbl_desc[t]),
         .rd_in_range(tbl_inrng[t])
      );
   end

   logic [REAL_W-1:0] real_pa;
   segxlat_real_path u_real (
      .seg  (selector),
      .off16(offset[15:0]),
      .phys (real_pa)
   );

   logic [LIN_W-1:0] prot_la;
   logic             prot_over;
   logic             prot_fault;
   segxlat_prot_path u_prot (
      .desc      (sel_local ? tbl_desc[1] : tbl_desc[0]),
      .in_range  (sel_local ? tbl_inrng[1] : tbl_inrng[0]),
      .off       (offset),
      .off_wide  (off_wide),
      .lin       (prot_la),
      .over_limit(prot_over),
      .fault     (prot_fault)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_out   <= '0;
         addr_valid <= 1'b0;
         addr_fault <= 1'b0;
      end else if (req_valid) begin
         if (!mode_prot) begin
            addr_out   <= {{(LIN_W-REAL_W){1'b0}}, real_pa};
            addr_valid <= 1'b1;
            addr_fault <= 1'b0;
         end else begin
            addr_out   <= prot_fault ? '0 : prot_la;
            addr_valid <= !prot_fault;
            addr_fault <= prot_fault;
         end
      end else begin
         addr_valid <= 1'b0;
         addr_fault <= 1'b0;
      end
   end

   p_excl_r11: assert property (@(posedge clk) disable iff (rst)
      !(addr_valid && addr_fault));

   p_idle_r11: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> (!addr_valid && !addr_fault));

   p_fault_zero_r11: assert property (@(posedge clk) disable iff (rst)
      addr_fault |-> (addr_out == '0));

   p_real_nofault_r3: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !mode_prot) |=> (addr_valid && !addr_fault));

   p_real_range_r1: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !mode_prot) |=> (addr_out[31:20] == '0));

   p_over_faults_r7: assert property (@(posedge clk) disable iff (rst)
      (req_valid && mode_prot && prot_over) |=> addr_fault);
endmodule

// File: tb/segxlat_unit_tb.sv
module segxlat_unit_tb;
   logic        clk = 0;
   logic        rst = 1;
   logic        req_valid = 0, mode_prot = 0, off_wide = 0;
   logic [15:0] selector = 0;
   logic [31:0] offset = 0;
   logic        wr_en = 0, wr_local = 0, wr_gran = 0, wr_present = 0;
   logic [3:0]  wr_index = 0;
   logic [31:0] wr_base = 0;
   logic [19:0] wr_limit = 0;
   logic [31:0] addr_out;
   logic        addr_valid, addr_fault;

   int errors = 0, checks = 0;
   bit done = 0;

   typedef struct packed { logic [31:0] a; logic v; logic f; } exp_t;
   exp_t  exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   segxlat_unit u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .mode_prot(mode_prot),
      .selector(selector), .offset(offset), .off_wide(off_wide),
      .wr_en(wr_en), .wr_local(wr_local), .wr_index(wr_index),
      .wr_base(wr_base), .wr_limit(wr_limit), .wr_gran(wr_gran),
      .wr_present(wr_present), .addr_out(addr_out),
      .addr_valid(addr_valid), .addr_fault(addr_fault));

   // monitor: samples 2 ns after each edge
   always begin
      @(posedge clk);
      begin
         logic took;
         took = req_valid && !rst;
         #2;
         if (took && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (addr_out !== e.a || addr_valid !== e.v || addr_fault !== e.f) begin
               errors++;
               $display("FAIL %s: got a=%h v=%0b f=%0b expected a=%h v=%0b f=%0b",
                        t, addr_out, addr_valid, addr_fault, e.a, e.v, e.f);
            end
         end else if (!took && !rst && (addr_valid || addr_fault)) begin
            checks++; errors++;
            $display("FAIL R11 idle: got v=%0b f=%0b expected v=0 f=0", addr_valid, addr_fault);
         end
      end
   end

   task automatic put_desc(input bit loc, input int idx, input logic [31:0] b,
                           input logic [19:0] l, input bit g, input bit p);
      @(negedge clk);
      wr_en = 1; wr_local = loc; wr_index = idx[3:0];
      wr_base = b; wr_limit = l; wr_gran = g; wr_present = p;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic xlat(input bit prot, input logic [15:0] s, input logic [31:0] o,
                       input bit w, input logic [31:0] ea, input bit ev,
                       input bit ef, input string tag);
      @(negedge clk);
      req_valid = 1; mode_prot = prot; selector = s; offset = o; off_wide = w;
      exp_q.push_back('{a: ea, v: ev, f: ef});
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (addr_out !== 0 || addr_valid !== 0 || addr_fault !== 0) begin
         errors++;
         $display("FAIL R12 reset outputs: got a=%h v=%0b f=%0b expected 0 0 0",
                  addr_out, addr_valid, addr_fault);
      end
      rst = 0;
      xlat(1, 16'h0000, 32'h0, 1, 32'h0, 0, 1, "R12 empty table");

      // real mode
      xlat(0, 16'h1100, 32'h450, 0, 32'h11450, 1, 0, "R1 1100:0450");
      xlat(0, 16'h1A2B, 32'h19A, 0, 32'h1A44A, 1, 0, "R1 1A2B:019A");
      xlat(0, 16'hFFFF, 32'h10, 0, 32'h00000, 1, 0, "R2 wrap to zero");
      xlat(0, 16'hFFFF, 32'hFFFF, 0, 32'h0FFEF, 1, 0, "R2 wrap max");
      xlat(0, 16'h3911, 32'hABCD_0200, 1, 32'h39310, 1, 0, "R3 upper offset ignored");

      // descriptor loads
      put_desc(0, 0,  32'h0001_0000, 20'h00FFF, 0, 1);
      put_desc(0, 5,  32'h8000_0000, 20'h00002, 1, 1);
      put_desc(1, 3,  32'h0040_0000, 20'h0FFFF, 0, 1);
      put_desc(1, 7,  32'h1234_0000, 20'hFFFFF, 1, 0);
      put_desc(0, 15, 32'h0000_0000, 20'hFFFFF, 1, 1);
      put_desc(0, 1,  32'hFFFF_F000, 20'hFFFFF, 1, 1);

      xlat(1, 16'h0000, 32'h0FFF, 1, 32'h0001_0FFF, 1, 0, "R7 at byte limit");
      xlat(1, 16'h0000, 32'h1000, 1, 32'h0, 0, 1, "R7 past byte limit");
      xlat(1, 16'h0003, 32'h10, 1, 32'h0001_0010, 1, 0, "R4 RPL ignored");
      xlat(1, 16'h001C, 32'h1234, 1, 32'h0040_1234, 1, 0, "R4 local idx3");
      xlat(1, 16'h0018, 32'h1234, 1, 32'h0, 0, 1, "R4 global idx3 absent");
      xlat(1, 16'h001C, 32'hFFFF_0010, 0, 32'h0040_0010, 1, 0, "R6 narrow offset");
      xlat(1, 16'h001C, 32'hFFFF_0010, 1, 32'h0, 0, 1, "R6 wide offset over");
      xlat(1, 16'h0028, 32'h2FFF, 1, 32'h8000_2FFF, 1, 0, "R8 at scaled limit");
      xlat(1, 16'h0028, 32'h3000, 1, 32'h0, 0, 1, "R8 past scaled limit");
      xlat(1, 16'h003C, 32'h0, 1, 32'h0, 0, 1, "R9 not present");
      xlat(1, 16'h0080, 32'h0, 1, 32'h0, 0, 1, "R10 index 16");
      xlat(1, 16'hFFF8, 32'h0, 1, 32'h0, 0, 1, "R10 index 8191");
      xlat(1, 16'h0078, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, 1, 0, "R5 flat max");
      xlat(1, 16'h0008, 32'h2000, 1, 32'h0000_1000, 1, 0, "R5 base wrap");

      // R13: write and request in the same cycle
      @(negedge clk);
      wr_en = 1; wr_local = 0; wr_index = 2; wr_base = 32'h0000_5000;
      wr_limit = 20'h000FF; wr_gran = 0; wr_present = 1;
      req_valid = 1; mode_prot = 1; selector = 16'h0010; offset = 32'h4; off_wide = 1;
      exp_q.push_back('{a: 32'h0, v: 1'b0, f: 1'b1});
      tag_q.push_back("R13 old contents seen");
      @(negedge clk);
      wr_en = 0; req_valid = 0;
      xlat(1, 16'h0010, 32'h4, 1, 32'h0000_5004, 1, 0, "R13 new contents after");

      // R12: reset mid-run clears tables
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      xlat(1, 16'h0000, 32'h10, 1, 32'h0, 0, 1, "R12 table cleared");
      xlat(1, 16'h001C, 32'h10, 1, 32'h0, 0, 1, "R12 local cleared");

      repeat (4) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R11 results missing: got %0d pending expected 0", exp_q.size());
      end
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule